// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block turns a single asynchronous serial line into received words of 8 or 9 bits, least significant bit first. A clock-enable tick at sixteen times the bit rate drives all of its timing: each bit is judged by a majority vote of three samples taken around its centre, and a start bit is accepted only if the line is still low at mid-bit. A finished word goes into a one-entry receive buffer; in 9-bit mode the top bit goes to a separate output instead of the buffer.

Five status flags describe what happened: buffer full, overrun, noise, framing error and idle line. They clear only through a two-step bus sequence: a status-read strobe, then a data-read strobe. Any flag-setting event that comes between the two steps cancels the sequence. Two interrupt lines come out. The receive interrupt follows the full and overrun flags, and the idle interrupt follows the idle flag. Each has its own enable and both obey a common mask. Noise and framing errors raise no interrupt of their own.

Top module: `uart_rx_stat`

## Requirements
- R1: After a start bit, 8 data bits sent LSB first and a high stop bit, the word appears on `rx_data`. At the same edge `flag_full` goes high, `rx_bit8` reads 0 and `flag_noise` and `flag_ferr` read 0.
- R2: With `word9`=1 a frame carries 9 data bits. The low 8 go to `rx_data` and the ninth to `rx_bit8`.
- R3: While `rx_en` is 0 the receiver ignores the line and completes no word. Once `rx_en` is 1 it hunts for a start bit.
- R4: A low pulse that has ended before the centre of the start bit is discarded. The receiver returns to hunting and sets no flag.
- R5: Each bit is the majority of oversampling ticks 7, 8 and 9 within the bit. If those three samples disagree on any bit of a frame, including the start and stop bits, `flag_noise` rises together with `flag_full` and the voted data is still stored.
- R6: A stop bit sampled low sets `flag_ferr` together with `flag_full`, and the data is still stored. A break (the line held low through the whole frame) stores 0 with `flag_ferr`. After a break, no new start is hunted until the line has returned high.
- R7: A word that completes while `flag_full` is set raises `flag_ovr`. The buffered word stays unchanged and the new word is discarded.
- R8: A `stat_rd` strobe followed later by a `data_rd` strobe clears all five flags, provided no flag-setting event lies between them or coincides with the `stat_rd`. A `data_rd` without such a preceding `stat_rd` leaves every flag unchanged.
- R9: `irq_rx` = (`flag_full` or `flag_ovr`) and `rie` and not `gmask`. Noise and framing flags alone raise no interrupt.
- R10: Once at least one word has been received, a continuous high line for one full frame time sets `flag_idle`. The frame time is 10 bit times (160 ticks), or 11 bit times (176 ticks) when `word9`=1. It sets the flag once per gap. `irq_idle` = `flag_idle` and `ilie` and not `gmask`.
- R11: If a word completes in the same cycle as a clearing `data_rd`, the old flags are cleared and the new word is loaded with `flag_full` set and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high, already synchronous to clk |
| rx_en | input | 1 | Receiver enable |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rie | input | 1 | Receive interrupt enable |
| ilie | input | 1 | Idle interrupt enable |
| gmask | input | 1 | Global interrupt mask, 1 blocks both interrupts |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_data | output | 8 | Receive buffer |
| rx_bit8 | output | 1 | Ninth data bit of the buffered word |
| flag_full | output | 1 | Receive buffer full |
| flag_ovr | output | 1 | Overrun |
| flag_noise | output | 1 | Noise seen in the buffered frame |
| flag_ferr | output | 1 | Framing error or break |
| flag_idle | output | 1 | Idle line detected |
| irq_rx | output | 1 | Receive interrupt |
| irq_idle | output | 1 | Idle interrupt |

## Verification
Two things can fall in the same clock edge: a word completing at the stop-bit vote, and a clearing data read. Completion happens 153 cycles after the first low sample of an 8-bit frame when the tick is held high. The bench arms the clear with a status read, then raises `data_rd` for exactly that cycle while it drives the second frame. It passes only if the new word is buffered with `flag_full` set and `flag_ovr` clear. A late read would instead show an overrun with the old word still held.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic [8:0] word;
        logic       noisy;
        logic       bad_stop;
    } rx_frame_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

endpackage

// File: rtl/rx_vote.sv
module rx_vote #(
    parameter int unsigned OSR = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   rxd,
    input  logic [$clog2(OSR)-1:0] phase,
    output logic                   vote,
    output logic                   disagree
);
    import uart_rx_pkg::*;

    localparam int unsigned CW = $clog2(OSR);
    localparam logic [CW-1:0] PH_A = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] PH_B = CW'(OSR / 2);

    logic samp_a, samp_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick) begin
            if (phase == PH_A) samp_a <= rxd;
            if (phase == PH_B) samp_b <= rxd;
        end
    end

    // third sample is the live line value at phase OSR/2+1
    always_comb begin
        vote     = maj3(samp_a, samp_b, rxd);
        disagree = split3(samp_a, samp_b, rxd);
    end

endmodule

// File: rtl/rx_deser.sv
module rx_deser #(
    parameter int unsigned OSR = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  rxd,
    input  logic                  rx_en,
    input  logic                  word9,
    output logic                  done,
    output uart_rx_pkg::rx_frame_t frame,
    output logic                  hunting
);
    import uart_rx_pkg::*;

    localparam int unsigned CW = $clog2(OSR);
    localparam logic [CW-1:0] PH_C   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] PH_END = CW'(OSR - 1);
    localparam logic [CW-1:0] PH_ONE = CW'(1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [3:0]    bidx;
    logic [8:0]    shreg;
    logic          noisy;
    logic          vote, disagree;
    logic [3:0]    last_bit;

    rx_vote #(.OSR(OSR)) vote_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxd      (rxd),
        .phase    (cnt),
        .vote     (vote),
        .disagree (disagree)
    );

    assign last_bit = word9 ? 4'd8 : 4'd7;
    assign hunting  = (state == ST_HUNT);
    assign done     = rx_en && tick && (state == ST_STOP) && (cnt == PH_C);

    always_comb begin
        frame.word     = {word9 & shreg[8], shreg[7:0]};
        frame.noisy    = noisy | disagree;
        frame.bad_stop = !vote;
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            state <= ST_HUNT;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            noisy <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_HUNT: begin
                    if (!rxd) begin
                        state <= ST_START;
                        cnt   <= PH_ONE;
                        noisy <= 1'b0;
                    end
                end
                ST_START: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == PH_C) begin
                        noisy <= noisy | disagree;
                        if (vote) state <= ST_HUNT;
                    end
                    if (cnt == PH_END) begin
                        state <= ST_DATA;
                        bidx  <= '0;
                    end
                end
                ST_DATA: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == PH_C) begin
                        shreg[bidx] <= vote;
                        noisy       <= noisy | disagree;
                    end
                    if (cnt == PH_END) begin
                        if (bidx == last_bit) state <= ST_STOP;
                        else                  bidx  <= bidx + 1'b1;
                    end
                end
                ST_STOP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == PH_C) state <= vote ? ST_HUNT : ST_WAITHI;
                end
                ST_WAITHI: begin
                    if (rxd) state <= ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    AST_DISABLED_HUNT: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> state == ST_HUNT); // R3

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (rx_en && tick && state == ST_START && cnt == PH_C && vote) |=> state == ST_HUNT); // R4

endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    input  logic rx_en,
    input  logic hunting,
    input  logic word9,
    input  logic char_done,
    output logic idle_pulse
);
    localparam int unsigned IW = $clog2(12 * OSR);
    localparam logic [IW-1:0] LIM8 = IW'(10 * OSR - 1);
    localparam logic [IW-1:0] LIM9 = IW'(11 * OSR - 1);

    logic [IW-1:0] run;
    logic          seen;
    logic [IW-1:0] lim;

    assign lim        = word9 ? LIM9 : LIM8;
    assign idle_pulse = seen && tick && rxd && hunting && (run == lim);

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            run  <= '0;
            seen <= 1'b0;
        end else begin
            if (char_done)       seen <= 1'b1;
            else if (idle_pulse) seen <= 1'b0;
            if (!rxd || !hunting || char_done) run <= '0;
            else if (tick && seen && run != lim) run <= run + 1'b1;
        end
    end

    AST_IDLE_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> !idle_pulse); // R10

endmodule

// File: rtl/rx_status.sv
module rx_status (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   done,
    input  uart_rx_pkg::rx_frame_t frame,
    input  logic                   idle_pulse,
    input  logic                   stat_rd,
    input  logic                   data_rd,
    input  logic                   rie,
    input  logic                   ilie,
    input  logic                   gmask,
    output logic [7:0]             rx_data,
    output logic                   rx_bit8,
    output logic                   flag_full,
    output logic                   flag_ovr,
    output logic                   flag_noise,
    output logic                   flag_ferr,
    output logic                   flag_idle,
    output logic                   irq_rx,
    output logic                   irq_idle
);
    import uart_rx_pkg::*;

    logic [8:0] buf_q;
    logic       full_q, ovr_q, noise_q, ferr_q, idle_q, armed_q;
    logic       clr;

    assign clr = data_rd && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
            noise_q <= 1'b0;
            ferr_q  <= 1'b0;
            idle_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (clr) begin
                full_q  <= 1'b0;
                ovr_q   <= 1'b0;
                noise_q <= 1'b0;
                ferr_q  <= 1'b0;
                idle_q  <= 1'b0;
            end
            if (done) begin
                if (!full_q || clr) begin
                    buf_q   <= frame.word;
                    full_q  <= 1'b1;
                    noise_q <= frame.noisy;
                    ferr_q  <= frame.bad_stop;
                end else begin
                    ovr_q <= 1'b1;
                end
            end
            if (idle_pulse) idle_q <= 1'b1;
            if (done || idle_pulse || clr) armed_q <= 1'b0;
            else if (stat_rd)              armed_q <= 1'b1;
        end
    end

    always_comb begin
        rx_data    = buf_q[7:0];
        rx_bit8    = buf_q[8];
        flag_full  = full_q;
        flag_ovr   = ovr_q;
        flag_noise = noise_q;
        flag_ferr  = ferr_q;
        flag_idle  = idle_q;
        irq_rx     = (full_q | ovr_q) & rie & !gmask;
        irq_idle   = idle_q & ilie & !gmask;
    end

    AST_OVR_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $stable(buf_q)); // R7

    AST_NOCLR_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !armed_q && full_q) |=> full_q); // R8

    AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && !full_q) |=> full_q); // R1

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       word9,
    input  logic       rie,
    input  logic       ilie,
    input  logic       gmask,
    input  logic       stat_rd,
    input  logic       data_rd,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       flag_full,
    output logic       flag_ovr,
    output logic       flag_noise,
    output logic       flag_ferr,
    output logic       flag_idle,
    output logic       irq_rx,
    output logic       irq_idle
);
    import uart_rx_pkg::*;

    logic      done, hunting, idle_pulse;
    rx_frame_t frame;

    rx_deser #(.OSR(OSR)) deser_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .rxd     (rxd),
        .rx_en   (rx_en),
        .word9   (word9),
        .done    (done),
        .frame   (frame),
        .hunting (hunting)
    );

    rx_idle_det #(.OSR(OSR)) idle_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .rxd        (rxd),
        .rx_en      (rx_en),
        .hunting    (hunting),
        .word9      (word9),
        .char_done  (done),
        .idle_pulse (idle_pulse)
    );

    rx_status status_i (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .frame      (frame),
        .idle_pulse (idle_pulse),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .rie        (rie),
        .ilie       (ilie),
        .gmask      (gmask),
        .rx_data    (rx_data),
        .rx_bit8    (rx_bit8),
        .flag_full  (flag_full),
        .flag_ovr   (flag_ovr),
        .flag_noise (flag_noise),
        .flag_ferr  (flag_ferr),
        .flag_idle  (flag_idle),
        .irq_rx     (irq_rx),
        .irq_idle   (irq_idle)
    );

endmodule

// File: tb/uart_rx_stat_tb.sv
module uart_rx_stat_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       word9 = 1'b0;
    logic       rie = 1'b1;
    logic       ilie = 1'b0;
    logic       gmask = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, flag_full, flag_ovr, flag_noise, flag_ferr, flag_idle;
    logic       irq_rx, irq_idle;

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_rx_stat dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
        .word9(word9), .rie(rie), .ilie(ilie), .gmask(gmask),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .flag_full(flag_full), .flag_ovr(flag_ovr),
        .flag_noise(flag_noise), .flag_ferr(flag_ferr), .flag_idle(flag_idle),
        .irq_rx(irq_rx), .irq_idle(irq_idle)
    );

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drives one frame from a negedge; signals set at cycle c are seen at posedge c
    task automatic send(input logic [8:0] w, input int nd, input logic stopv,
                        input int glitch_at, input int rd_at);
        int total = (nd + 2) * 16;
        for (int c = 0; c < total; c++) begin
            int b = c / 16;
            logic v;
            if (b == 0)           v = 1'b0;
            else if (b <= nd)     v = w[b-1];
            else                  v = stopv;
            rxd     = (c == glitch_at) ? ~v : v;
            data_rd = (c == rd_at);
            @(negedge clk);
        end
        rxd     = 1'b1;
        data_rd = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int n);
        rxd = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear;
        stat_rd = 1'b1; @(negedge clk);
        stat_rd = 1'b0; data_rd = 1'b1; @(negedge clk);
        data_rd = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset full", flag_full, 0);
        check("R9 reset irq_rx", irq_rx, 0);
        check("R1 reset data", rx_data, 0);
    endtask

    task automatic t_basic;
        send(9'h0A5, 8, 1'b1, -1, -1);
        check("R1 full", flag_full, 1);
        check("R1 data", rx_data, 8'hA5);
        check("R1 bit8", rx_bit8, 0);
        check("R1 noise", flag_noise, 0);
        check("R1 ferr", flag_ferr, 0);
        check("R9 irq_rx", irq_rx, 1);
        do_clear();
        check("R8 cleared", flag_full, 0);
    endtask

    task automatic t_unarmed_read;
        send(9'h03C, 8, 1'b1, -1, -1);
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
        check("R8 data read alone keeps full", flag_full, 1);
        check("R8 data kept", rx_data, 8'h3C);
        do_clear();
        check("R8 clear after status", flag_full, 0);
    endtask

    task automatic t_nine;
        word9 = 1'b1;
        send(9'h15A, 9, 1'b1, -1, -1);
        check("R2 data", rx_data, 8'h5A);
        check("R2 bit8", rx_bit8, 1);
        do_clear();
        word9 = 1'b0;
    endtask

    task automatic t_noise;
        send(9'h0C3, 8, 1'b1, 3 * 16 + 8, -1);
        check("R5 full", flag_full, 1);
        check("R5 noise", flag_noise, 1);
        check("R5 voted data", rx_data, 8'hC3);
        check("R9 irq follows full only", irq_rx, 1);
        do_clear();
        check("R5 noise cleared", flag_noise, 0);
    endtask

    task automatic t_frame_err;
        send(9'h07E, 8, 1'b0, -1, -1);
        hold(1'b1, 4);
        check("R6 ferr", flag_ferr, 1);
        check("R6 data", rx_data, 8'h7E);
        do_clear();
    endtask

    task automatic t_break;
        hold(1'b0, 10 * 16 + 40);
        check("R6 break full", flag_full, 1);
        check("R6 break ferr", flag_ferr, 1);
        check("R6 break data", rx_data, 0);
        do_clear();
        hold(1'b0, 60);
        check("R6 no restart while low", flag_full, 0);
        hold(1'b1, 20);
    endtask

    task automatic t_false_start;
        hold(1'b0, 5);
        hold(1'b1, 200);
        check("R4 false start ignored", flag_full, 0);
        do_clear();
    endtask

    task automatic t_disabled;
        rx_en = 1'b0;
        send(9'h099, 8, 1'b1, -1, -1);
        check("R3 disabled no word", flag_full, 0);
        rx_en = 1'b1;
        hold(1'b1, 4);
    endtask

    task automatic t_overrun;
        send(9'h011, 8, 1'b1, -1, -1);
        send(9'h022, 8, 1'b1, -1, -1);
        check("R7 ovr", flag_ovr, 1);
        check("R7 old word kept", rx_data, 8'h11);
        check("R9 irq on ovr", irq_rx, 1);
        gmask = 1'b1; @(negedge clk);
        check("R9 masked", irq_rx, 0);
        gmask = 1'b0;
        do_clear();
        check("R8 ovr cleared", flag_ovr, 0);
    endtask

    task automatic t_idle;
        ilie = 1'b1;
        send(9'h044, 8, 1'b1, -1, -1);
        do_clear();
        hold(1'b1, 100);
        check("R10 idle not yet", flag_idle, 0);
        hold(1'b1, 100);
        check("R10 idle set", flag_idle, 1);
        check("R10 irq_idle", irq_idle, 1);
        check("R9 idle gives no irq_rx", irq_rx, 0);
        gmask = 1'b1; @(negedge clk);
        check("R10 irq_idle masked", irq_idle, 0);
        gmask = 1'b0;
        do_clear();
        check("R10 idle cleared", flag_idle, 0);
        hold(1'b1, 250);
        check("R10 once per gap", flag_idle, 0);
        ilie = 1'b0;
    endtask

    task automatic t_same_cycle;
        send(9'h055, 8, 1'b1, -1, -1);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
        send(9'h066, 8, 1'b1, -1, 9 * 16 + 9);
        check("R11 full", flag_full, 1);
        check("R11 no ovr", flag_ovr, 0);
        check("R11 new word", rx_data, 8'h66);
        do_clear();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        @(negedge clk);
        t_basic();
        t_unarmed_read();
        t_nine();
        t_noise();
        t_frame_err();
        t_break();
        t_false_start();
        t_disabled();
        t_overrun();
        t_idle();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule